// File: doc/BRIEF.md
# Serial Receiver with Status Flags

This block turns an asynchronous serial line into characters and holds them for a host. Each frame has four parts, sent least significant bit first: a low start bit, the data bits, one address bit and a high stop bit. The line first passes through a synchronizer. It is then oversampled under a clock-enable that pulses sixteen times per bit period. Each bit is taken at the middle of its bit period.

A finished character lands in a one-entry data register. If that register is still occupied, the character waits in a parking stage behind it. Each character keeps its own address bit as it moves through these two places. The host sees a ready flag, an address flag and an overrun flag, and it gets an interrupt request line.

The host reads through a small register port. One select chooses between the data view and the status view. A read strobe on the data view consumes the character. A parked character then moves forward on the same clock edge.

Top module: `serial_rx_flags`

## Requirements
- R1: After a synchronous reset, the data view and the status view both read 0x00 and `rx_irq` is low.
- R2: The bit period is 16 `os_tick` pulses. A line fall is accepted as a start bit only if the line is still low 8 ticks later. Each later bit is sampled every 16 ticks after that. Only clock cycles with `os_tick` high advance the receiver. The line passes through `SYNC_STAGES` registers, which reset high, before the receiver sees it.
- R3: A low pulse on the line that has ended by the mid-start sample produces no character, and no flag changes.
- R4: Status bit 7 (ready) is set when a character enters the data register. It is cleared by a data-view read when no character is waiting to move in.
- R5: Status bit 6 shows the address bit of the character now in the data register, and it is 0 whenever ready is 0. With `wide_mode`=1 a frame carries 8 data bits and then the address bit. With `wide_mode`=0 it carries 7 data bits and then the address bit, and data bit 7 reads as 0. The mode is latched when the start bit is accepted.
- R6: A character that completes while the data register is full is parked. On a data-view read it moves into the data register on the same edge, with its own address bit, and ready stays 1.
- R7: Status bit 5 (overrun) is set when a start bit is accepted while both the data register and the parking stage are full. The character that follows is discarded, and the two held characters are unchanged.
- R8: A data-view read clears overrun, unless a new overrun occurs on the same edge.
- R9: `rx_irq` is set on every edge that loads a character into the data register, which includes each 0-to-1 change of ready. A data-view read that loads nothing clears it.
- R10: With `rd_sel`=1 the status view is shown, and bits 4 to 0 read 0. A read strobe with `rd_sel`=1 changes no state. With `rd_sel`=0 the data view is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| wide_mode | input | 1 | 1: 8 data bits plus address bit; 0: 7 data bits plus address bit |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | View select: 0 data, 1 status |
| rd_value | output | 8 | Selected view |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench targets the moment a character completes on the same edge as a data read. A design that gets this wrong either loses the parked character or shows a stale address bit next to the new data. Three frames are sent back to back with no read between them. A design that checks overrun against the data register alone would raise the flag one frame too early, and one that does not discard the third character would overwrite the parked one. A start glitch and a 7-bit frame are also sent. A receiver that does not check the start bit again at its middle would output a false character, and one that places the narrow address bit in the wrong position would set the wrong data bit 7 and the wrong status bit 6.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int CHAR_W   = 8;
    localparam int ST_READY = 7;
    localparam int ST_ADDR  = 6;
    localparam int ST_OVR   = 5;

    typedef struct packed {
        logic              addr;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_e;

    // Shift register holds the last CHAR_W+1 bits, newest at the top.
    function automatic rx_char_t unpack_frame(input logic [CHAR_W:0] sh,
                                              input logic wide);
        rx_char_t c;
        c.addr = sh[CHAR_W];
        if (wide) c.data = sh[CHAR_W-1:0];
        else      c.data = {1'b0, sh[CHAR_W-1:1]};
        return c;
    endfunction

    function automatic logic [CHAR_W-1:0] pack_status(input logic rdy,
                                                      input logic adr,
                                                      input logic ovr);
        logic [CHAR_W-1:0] s;
        s           = '0;
        s[ST_READY] = rdy;
        s[ST_ADDR]  = rdy & adr;
        s[ST_OVR]   = ovr;
        return s;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_deser.sv
module srx_deser
    import srx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line,
    input  logic     tick,
    input  logic     wide_mode,
    output logic     start_ok,
    output logic     done,
    output rx_char_t chr
);
    localparam int CNT_W  = $clog2(OS_RATE);
    localparam int MID    = OS_RATE / 2 - 1;
    localparam int LAST   = OS_RATE - 1;
    localparam int BCNT_W = $clog2(CHAR_W + 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BCNT_W-1:0] nbit;
    logic [CHAR_W:0]   sh;
    logic              wide_q;
    logic [BCNT_W-1:0] last_bit;

    assign last_bit = wide_q ? BCNT_W'(CHAR_W) : BCNT_W'(CHAR_W - 1);
    assign start_ok = tick && (state == RX_START) && (cnt == CNT_W'(MID)) && !line;
    assign done     = tick && (state == RX_STOP) && (cnt == CNT_W'(LAST));
    assign chr      = unpack_frame(sh, wide_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            nbit   <= '0;
            sh     <= '0;
            wide_q <= 1'b1;
        end else if (tick) begin
            unique case (state)
                RX_IDLE: begin
                    if (!line) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == CNT_W'(MID)) begin
                        cnt  <= '0;
                        nbit <= '0;
                        sh   <= '0;
                        if (!line) begin
                            state  <= RX_BITS;
                            wide_q <= wide_mode;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (cnt == CNT_W'(LAST)) begin
                        cnt  <= '0;
                        sh   <= {line, sh[CHAR_W:1]};
                        nbit <= nbit + 1'b1;
                        if (nbit == last_bit) state <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == CNT_W'(LAST)) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_ok,
    input  logic     done,
    input  rx_char_t chr,
    input  logic     rd_take,
    output rx_char_t cur,
    output logic     ready,
    output logic     ovr,
    output logic     irq,
    output logic     pend_valid
);
    rx_char_t pend;
    logic     drop;
    logic     done_keep, load_pend, load_new, park_new, any_load;

    always_comb begin
        done_keep = done && !drop;
        load_pend = rd_take && pend_valid;
        load_new  = done_keep && ((rd_take && !pend_valid) || (!rd_take && !ready));
        park_new  = done_keep && !load_new;
        any_load  = load_pend || load_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '0;
            pend       <= '0;
            ready      <= 1'b0;
            pend_valid <= 1'b0;
            ovr        <= 1'b0;
            irq        <= 1'b0;
            drop       <= 1'b0;
        end else begin
            if (start_ok) drop <= pend_valid;

            if (load_pend)     cur <= pend;
            else if (load_new) cur <= chr;

            if (any_load)     ready <= 1'b1;
            else if (rd_take) ready <= 1'b0;

            if (park_new) begin
                pend       <= chr;
                pend_valid <= 1'b1;
            end else if (load_pend) begin
                pend_valid <= 1'b0;
            end

            if (start_ok && pend_valid) ovr <= 1'b1;
            else if (rd_take)           ovr <= 1'b0;

            if (any_load)     irq <= 1'b1;
            else if (rd_take) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
    import srx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              wide_mode,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [CHAR_W-1:0] rd_value,
    output logic              rx_irq
);
    logic     line_s;
    logic     start_ok, done;
    rx_char_t chr, cur;
    logic     flag_ready, flag_ovr, pend_valid, rd_take;

    assign rd_take = rd_en && !rd_sel;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(rx_line), .q(line_s)
    );

    srx_deser #(.OS_RATE(OS_RATE)) u_deser (
        .clk(clk), .rst(rst), .line(line_s), .tick(os_tick),
        .wide_mode(wide_mode), .start_ok(start_ok), .done(done), .chr(chr)
    );

    srx_hold u_hold (
        .clk(clk), .rst(rst), .start_ok(start_ok), .done(done), .chr(chr),
        .rd_take(rd_take), .cur(cur), .ready(flag_ready), .ovr(flag_ovr),
        .irq(rx_irq), .pend_valid(pend_valid)
    );

    assign rd_value = rd_sel ? pack_status(flag_ready, cur.addr, flag_ovr) : cur.data;
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic       rd_sel,
    input logic [7:0] rd_value,
    input logic       irq,
    input logic       ready,
    input logic       ovr,
    input logic       pend_v
);
    // R4
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(rd_en && !rd_sel));

    // R8
    ovr_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovr) |-> $past(rd_en && !rd_sel));

    // R7
    ovr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(pend_v));

    // R6
    pend_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        pend_v |-> ready);

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ready);

    // R10
    status_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_sel |-> (rd_value[4:0] == 5'd0));
endmodule

bind serial_rx_flags srx_chk i_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel), .rd_value(rd_value),
    .irq(rx_irq), .ready(flag_ready), .ovr(flag_ovr), .pend_v(pend_valid)
);

// File: tb/test_serial_rx_flags.sv
module test_serial_rx_flags;
    localparam int OS   = 16;
    localparam int SYNC = 2;
    localparam int TDIV = 2;
    localparam int BITC = OS * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       wide_mode = 1'b1;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_value;
    logic       rx_irq;

    int checks = 0;
    int fails  = 0;

    serial_rx_flags #(.OS_RATE(OS), .SYNC_STAGES(SYNC)) i_serial_rx_flags (
        .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
        .wide_mode(wide_mode), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_value(rd_value), .rx_irq(rx_irq)
    );

    always #5 clk = ~clk;

    int tdiv = 0;
    always @(negedge clk) begin
        tdiv    = (tdiv + 1) % TDIV;
        os_tick = (tdiv == 0);
    end

    // Behavioural reference model
    typedef struct { int data; int addr; } ch_t;
    ch_t held[$];
    int  dl[SYNC];
    int  ms, mc, nb, acc, mw, mdrop;
    int  m_cur, m_adr, m_ovr, m_irq;

    function automatic int exp_view(input logic sel);
        int s;
        if (!sel) return m_cur;
        s = 0;
        if (held.size() > 0) s = s | 128 | (m_adr << 6);
        s = s | (m_ovr << 5);
        return s;
    endfunction

    always @(posedge clk) begin
        int  v, st_ev, dn, loaded, take;
        ch_t nc;
        if (rst) begin
            held.delete();
            for (int i = 0; i < SYNC; i++) dl[i] = 1;
            ms = 0; mc = 0; nb = 0; acc = 0; mw = 1; mdrop = 0;
            m_cur = 0; m_adr = 0; m_ovr = 0; m_irq = 0;
        end else begin
            v = dl[SYNC-1];
            for (int i = SYNC - 1; i > 0; i--) dl[i] = dl[i-1];
            dl[0] = rx_line;
            st_ev = 0; dn = 0;
            if (os_tick) begin
                case (ms)
                    0: if (v == 0) begin ms = 1; mc = 0; end
                    1: if (mc == OS / 2 - 1) begin
                           mc = 0;
                           if (v == 0) begin ms = 2; nb = 0; acc = 0; mw = wide_mode; st_ev = 1; end
                           else ms = 0;
                       end else mc++;
                    2: if (mc == OS - 1) begin
                           mc = 0; acc = acc | (v << nb); nb++;
                           if (nb == (mw ? 9 : 8)) ms = 3;
                       end else mc++;
                    default: if (mc == OS - 1) begin mc = 0; ms = 0; dn = 1; end else mc++;
                endcase
            end
            take = rd_en && !rd_sel;
            if (st_ev) begin
                mdrop = (held.size() == 2);
                if (mdrop) m_ovr = 1;
            end else if (take) m_ovr = 0;
            loaded = 0;
            if (take && held.size() > 0) begin
                void'(held.pop_front());
                if (held.size() > 0) loaded = 1;
            end
            if (dn && !mdrop) begin
                if (mw) begin nc.data = acc & 255; nc.addr = (acc >> 8) & 1; end
                else    begin nc.data = acc & 127; nc.addr = (acc >> 7) & 1; end
                if (held.size() == 0) loaded = 1;
                held.push_back(nc);
            end
            if (held.size() > 0) begin m_cur = held[0].data; m_adr = held[0].addr; end
            if (loaded) m_irq = 1; else if (take) m_irq = 0;
            #2;
            checks++;
            if (rd_value !== 8'(exp_view(rd_sel)) || rx_irq !== 1'(m_irq)) begin
                fails++;
                $display("FAIL R2/R4/R5/R6/R7/R9 model compare sel=%0d: actual %h/%b expected %h/%0d",
                         rd_sel, rd_value, rx_irq, exp_view(rd_sel), m_irq);
            end
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic peek(input logic sel, output int val);
        @(negedge clk);
        rd_en  = 1'b0;
        rd_sel = sel;
        #1 val = int'(rd_value);
    endtask

    task automatic read_data();
        @(negedge clk);
        rd_sel = 1'b0;
        rd_en  = 1'b1;
        @(negedge clk);
        rd_en  = 1'b0;
    endtask

    task automatic send(input int nbits, input int pattern);
        rx_line = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rx_line = 1'((pattern >> i) & 1);
            repeat (BITC) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int val;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        peek(1'b1, val); chk("R1 status", val, 8'h00);
        peek(1'b0, val); chk("R1 data", val, 8'h00);
        chk("R1 irq", int'(rx_irq), 0);

        // R2 R5 wide frame 0xA5 with address bit
        wide_mode = 1'b1;
        @(negedge clk);
        send(9, 9'h1A5);
        repeat (10) @(negedge clk);
        peek(1'b1, val); chk("R4 R5 status after frame", val, 8'hC0);
        peek(1'b0, val); chk("R2 data", val, 8'hA5);
        chk("R9 irq set", int'(rx_irq), 1);

        // R10 status read has no effect
        @(negedge clk); rd_sel = 1'b1; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        peek(1'b1, val); chk("R10 status kept", val, 8'hC0);
        chk("R10 irq kept", int'(rx_irq), 1);

        // R4 R9 consume
        read_data();
        peek(1'b1, val); chk("R4 ready cleared", val, 8'h00);
        chk("R9 irq cleared", int'(rx_irq), 0);

        // R5 R6 narrow frames: 0x5A addr 1, then 0x33 addr 0 parked
        wide_mode = 1'b0;
        send(8, 9'h0DA);
        send(8, 9'h033);
        repeat (10) @(negedge clk);
        peek(1'b0, val); chk("R5 narrow data", val, 8'h5A);
        peek(1'b1, val); chk("R6 status with parked", val, 8'hC0);
        read_data();
        peek(1'b0, val); chk("R6 parked moved in", val, 8'h33);
        peek(1'b1, val); chk("R6 ready held, addr follows", val, 8'h80);
        chk("R9 irq on refill", int'(rx_irq), 1);
        read_data();
        peek(1'b1, val); chk("R4 empty again", val, 8'h00);

        // R7 R8 overrun on third frame
        wide_mode = 1'b1;
        send(9, 9'h011);
        send(9, 9'h122);
        send(9, 9'h033);
        repeat (10) @(negedge clk);
        peek(1'b1, val); chk("R7 overrun set", val, 8'hA0);
        peek(1'b0, val); chk("R7 data kept", val, 8'h11);
        read_data();
        peek(1'b1, val); chk("R8 overrun cleared", val, 8'hC0);
        peek(1'b0, val); chk("R7 parked kept", val, 8'h22);
        read_data();
        peek(1'b1, val); chk("R7 third discarded", val, 8'h00);

        // R3 start glitch
        @(negedge clk); rx_line = 1'b0;
        repeat (6) @(negedge clk); rx_line = 1'b1;
        repeat (BITC * 12) @(negedge clk);
        peek(1'b1, val); chk("R3 glitch ignored", val, 8'h00);
        chk("R3 irq quiet", int'(rx_irq), 0);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule